// File: doc/BRIEF.md
# Data memory access router

This block sits between a processor's load/store unit and two data memories. One is a 1 kB on-chip SRAM, which the block holds as an inferred array. The other is an external memory reached over a request/acknowledge bus. Each access carries a 16-bit address, a read or write strobe and write data. The block decides where the access goes from the address and a 2-bit enable field.

The internal SRAM is used only when the enable field is nonzero and the address is below 0400h. Every other access goes to the external bus. An internal access completes in one clock. An external access keeps its request, address and data steady until the far side acknowledges. The requester sees a single `done` pulse and, for reads, the returned byte on `rdata`.

Only one external access can be in flight. Strobes that arrive while it is pending are dropped.

Top module: `dmem_router`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `done` and `ext_req` are 0.
- R2: With `mem_en` = 00 every access goes to the external bus, including addresses 0000h–03FFh.
- R3: With `mem_en` at 01, 10 or 11, an access to an address below 0400h goes to the internal SRAM and does not raise `ext_req`. An internal read returns the last byte written internally at that address.
- R4: An access to an address at or above 0400h goes to the external bus for every `mem_en` value.
- R5: An internal access is accepted at the clock edge where its strobe is sampled. `done` is high, and for a read `rdata` is valid, in the very next cycle. A new internal access may be sampled at that next edge.
- R6: An external access raises `ext_req` in the cycle after its strobe is sampled. `ext_addr`, `ext_we` (1 = write) and `ext_wdata` hold their values until `ext_ack` is sampled high.
- R7: When `ext_ack` is sampled high while `ext_req` is high, `ext_req` falls and `done` is high for exactly the next cycle. For a read, `rdata` then shows the `ext_rdata` value sampled with the acknowledge.
- R8: Strobes sampled while `ext_req` is high are ignored. They do not write the SRAM, do not start a new request and do not change the pending address.
- R9: If `req_rd` and `req_wr` are both high, the access is a write.
- R10: `ext_ack` sampled while `ext_req` is low has no effect, and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_en | input | 2 | Internal memory enable; 00 turns it off |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe, wins over read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rdata | output | 8 | Read result |
| done | output | 1 | Access complete pulse |
| ext_req | output | 1 | External request, held until acknowledged |
| ext_we | output | 1 | External direction, 1 = write |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write data |
| ext_ack | input | 1 | External acknowledge |
| ext_rdata | input | 8 | External read data, sampled with ack |

## Verification
An internal result is due one cycle after the edge that samples the strobe. An external request is visible one cycle after that edge. The external `done` and read data appear one cycle after the edge that samples `ext_ack`. The bench changes inputs on falling edges and reads outputs on the following falling edge, so each check sits exactly one register stage after the stimulus it answers. Its external memory model holds the acknowledge back for a chosen number of cycles and checks that the request fields stay steady in each of those cycles.

// File: rtl/dmem_router_pkg.sv
package dmem_router_pkg;

  typedef enum logic [1:0] {
    DEST_NONE = 2'd0,
    DEST_INT  = 2'd1,
    DEST_EXT  = 2'd2
  } dest_e;

endpackage

// File: rtl/dmem_route_decode.sv
module dmem_route_decode
  import dmem_router_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int EN_W      = 2,
  parameter int INT_BYTES = 1024
) (
  input  logic              rd,
  input  logic              wr,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [EN_W-1:0]   en,
  output dest_e             dest,
  output logic              is_write
);

  localparam logic [ADDR_W-1:0] INT_LIMIT = ADDR_W'(INT_BYTES);

  function automatic logic in_int_window(input logic [ADDR_W-1:0] a,
                                         input logic [EN_W-1:0]   e);
    return (e != '0) && (a < INT_LIMIT);
  endfunction

  logic strobe;
  assign strobe   = (rd | wr) & ~busy;
  assign is_write = wr;

  always_comb begin
    if (!strobe)                  dest = DEST_NONE;
    else if (in_int_window(addr, en)) dest = DEST_INT;
    else                          dest = DEST_EXT;
  end

endmodule

// File: rtl/dmem_sram.sv
module dmem_sram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
    if (re) rdata <= cells[idx];
  end

endmodule

// File: rtl/dmem_ext_port.sv
module dmem_ext_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              ack,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              finish
);

  assign finish = req & ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req   <= 1'b0;
      we    <= 1'b0;
      addr  <= '0;
      wdata <= '0;
    end else if (finish) begin
      req <= 1'b0;
    end else if (start && !req) begin
      req   <= 1'b1;
      we    <= start_we;
      addr  <= start_addr;
      wdata <= start_wdata;
    end
  end

  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(addr) && $stable(we) && $stable(wdata))); // R6

endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmem_router_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int EN_W      = 2,
  parameter int INT_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EN_W-1:0]   mem_en,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              ext_req,
  output logic              ext_we,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic              ext_ack,
  input  logic [DATA_W-1:0] ext_rdata
);

  localparam int IDX_W = $clog2(INT_BYTES);
  localparam logic [ADDR_W-1:0] INT_LIMIT = ADDR_W'(INT_BYTES);

  dest_e             dest;
  logic              acc_write;
  logic              int_fire;
  logic              ext_fire;
  logic              sram_we;
  logic              sram_re;
  logic              ext_finish;
  logic [DATA_W-1:0] sram_q;
  logic [DATA_W-1:0] ext_q;
  logic              sel_int_q;
  logic              done_q;

  dmem_route_decode #(
    .ADDR_W(ADDR_W), .EN_W(EN_W), .INT_BYTES(INT_BYTES)
  ) u_decode (
    .rd(req_rd), .wr(req_wr), .busy(ext_req), .addr(req_addr),
    .en(mem_en), .dest(dest), .is_write(acc_write)
  );

  assign int_fire = (dest == DEST_INT);
  assign ext_fire = (dest == DEST_EXT);
  assign sram_we  = int_fire & acc_write;
  assign sram_re  = int_fire & ~acc_write;

  dmem_sram #(.DATA_W(DATA_W), .DEPTH(INT_BYTES)) u_sram (
    .clk(clk), .we(sram_we), .re(sram_re),
    .idx(req_addr[IDX_W-1:0]), .wdata(req_wdata), .rdata(sram_q)
  );

  dmem_ext_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .start(ext_fire), .start_we(acc_write),
    .start_addr(req_addr), .start_wdata(req_wdata), .ack(ext_ack),
    .req(ext_req), .we(ext_we), .addr(ext_addr), .wdata(ext_wdata),
    .finish(ext_finish)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      sel_int_q <= 1'b0;
      ext_q     <= '0;
    end else begin
      done_q <= int_fire | ext_finish;
      if (sram_re) sel_int_q <= 1'b1;
      if (ext_finish && !ext_we) begin
        sel_int_q <= 1'b0;
        ext_q     <= ext_rdata;
      end
    end
  end

  assign done  = done_q;
  assign rdata = sel_int_q ? sram_q : ext_q;

  AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_ack) |=> (done && !ext_req)); // R7

  AST_BUSY_NO_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> !sram_we); // R8

  AST_HIGH_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_rd || req_wr) && !ext_req && req_addr >= INT_LIMIT) |=> (ext_req && !done)); // R4

  AST_OFF_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_rd || req_wr) && !ext_req && mem_en == '0) |=> (ext_req && !done)); // R2

  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_req && !req_rd && !req_wr) |=> !done); // R10

endmodule

// File: tb/dmem_router_bench.sv
module dmem_router_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mem_en = 2'b00;
  logic        req_rd = 1'b0, req_wr = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rdata;
  logic        done, ext_req, ext_we;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic        ext_ack = 1'b0;
  logic [7:0]  ext_rdata = '0;

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_router u_dmem_router (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdata(rdata), .done(done),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_ack(ext_ack), .ext_rdata(ext_rdata)
  );

  function automatic logic goes_int(input logic [15:0] a, input logic [1:0] e);
    return (e != 2'b00) && (a < 16'h0400);
  endfunction

  function automatic logic [7:0] ext_pattern(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // One access; inputs change at falling edges, outputs read one falling edge later
  task automatic run_access(input logic is_wr, input logic [15:0] a,
                            input logic [7:0] d, input int lat);
    logic internal;
    string tag;
    internal = goes_int(a, mem_en);
    tag = (a >= 16'h0400) ? "R4" : ((mem_en == 2'b00) ? "R2" : "R3");
    @(negedge clk);
    req_rd = !is_wr; req_wr = is_wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    if (internal) begin
      check(done == 1'b1, "R5", done, 1);
      check(ext_req == 1'b0, "R3", ext_req, 0);
      if (is_wr) shadow[a[9:0]] = d;
      else check(rdata == shadow[a[9:0]], "R3", rdata, shadow[a[9:0]]);
    end else begin
      check(ext_req == 1'b1, tag, ext_req, 1);
      check(ext_addr == a && ext_we == is_wr, "R6", ext_addr, a);
      if (is_wr) check(ext_wdata == d, "R6", ext_wdata, d);
      check(done == 1'b0, "R6", done, 0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        check(ext_req && ext_addr == a && ext_we == is_wr, "R6", ext_addr, a);
      end
      ext_ack = 1'b1; ext_rdata = ext_pattern(a);
      @(negedge clk);
      ext_ack = 1'b0;
      check(done == 1'b1 && ext_req == 1'b0, "R7", {done, ext_req}, 2'b10);
      if (!is_wr) check(rdata == ext_pattern(a), "R7", rdata, ext_pattern(a));
      @(negedge clk);
      check(done == 1'b0, "R7", done, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [15:0] addrs [9];
    addrs = '{16'h0000, 16'h0001, 16'h01FF, 16'h03FE, 16'h03FF,
              16'h0400, 16'h0401, 16'h7FFF, 16'hFFFF};
    mem_en = 2'b11;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && ext_req == 1'b0, "R1", {done, ext_req}, 0);
    rst_n = 1'b1;
    mem_en = 2'b00;
    @(negedge clk);
    check(done == 1'b0 && ext_req == 1'b0, "R1", {done, ext_req}, 0);

    // sweep of every enable value across the window boundary
    for (int e = 0; e < 4; e++) begin
      mem_en = 2'(e);
      foreach (addrs[k]) begin
        run_access(1'b1, addrs[k], 8'(addrs[k]) ^ 8'(e * 37) ^ 8'hC3, k % 3);
        run_access(1'b0, addrs[k], 8'h00, (k + e) % 4);
      end
    end

    // R5: back-to-back internal write then read
    mem_en = 2'b01;
    @(negedge clk);
    req_wr = 1'b1; req_addr = 16'h0040; req_wdata = 8'h9C;
    @(negedge clk);
    check(done == 1'b1, "R5", done, 1);
    req_wr = 1'b0; req_rd = 1'b1;
    @(negedge clk);
    req_rd = 1'b0;
    check(done == 1'b1 && rdata == 8'h9C, "R5", rdata, 8'h9C);
    shadow[10'h040] = 8'h9C;

    // R8: strobes during a pending external read
    run_access(1'b1, 16'h0020, 8'h11, 0);
    @(negedge clk);
    req_rd = 1'b1; req_addr = 16'h0500;
    @(negedge clk);
    req_rd = 1'b0;
    req_wr = 1'b1; req_addr = 16'h0020; req_wdata = 8'hEE;
    @(negedge clk);
    req_wr = 1'b0; req_rd = 1'b1; req_addr = 16'h0600;
    @(negedge clk);
    req_rd = 1'b0;
    check(ext_req && ext_addr == 16'h0500 && ext_we == 1'b0, "R8", ext_addr, 16'h0500);
    check(done == 1'b0, "R8", done, 0);
    ext_ack = 1'b1; ext_rdata = 8'h3D;
    @(negedge clk);
    ext_ack = 1'b0;
    check(done && rdata == 8'h3D, "R7", rdata, 8'h3D);
    @(negedge clk);
    check(ext_req == 1'b0 && done == 1'b0, "R8", {ext_req, done}, 0);
    run_access(1'b0, 16'h0020, 8'h00, 0);
    check(shadow[10'h020] == 8'h11, "R8", shadow[10'h020], 8'h11);

    // R9: both strobes count as a write
    @(negedge clk);
    req_rd = 1'b1; req_wr = 1'b1; req_addr = 16'h0030; req_wdata = 8'h77;
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    check(done == 1'b1, "R9", done, 1);
    shadow[10'h030] = 8'h77;
    run_access(1'b0, 16'h0030, 8'h00, 0);
    @(negedge clk);
    req_rd = 1'b1; req_wr = 1'b1; req_addr = 16'h0900; req_wdata = 8'h42;
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    check(ext_req && ext_we && ext_wdata == 8'h42, "R9", {ext_we, ext_wdata}, 9'h142);
    ext_ack = 1'b1;
    @(negedge clk);
    ext_ack = 1'b0;
    @(negedge clk);

    // R10: stray acknowledge while idle
    ext_ack = 1'b1;
    @(negedge clk);
    ext_ack = 1'b0;
    check(done == 1'b0 && ext_req == 1'b0, "R10", {done, ext_req}, 0);
    @(negedge clk);
    check(done == 1'b0, "R10", done, 0);

    finish_run();
  end

endmodule